// File: doc/BRIEF.md
# Vector Element Broadcast Unit

This execution-stage datapath takes one 128-bit SIMD source value and a 5-bit immediate. The position of the lowest set bit in the low four immediate bits gives the element width: 8, 16, 32 or 64 bits. The bits above that marker give the element index. The selected element is then handled in one of two ways. It can be copied into every lane of a 64-bit or 128-bit destination, with the width chosen by a Q bit. Or it can be written alone as a scalar, with every higher bit cleared.

Encodings that cannot execute raise a one-cycle undefined flag in place of a result. Each accepted request produces its outcome exactly one clock later, whatever the data or the encoding. The result register keeps its value until the next legal request.

Top module: `vec_bcast_unit`

## Requirements
- R1: The element width is 8 << k, where k is the position of the lowest set bit of imm[3:0] (bit 0 → 8, bit 1 → 16, bit 2 → 32, bit 3 → 64).
- R2: When imm[3:0] is 0000, the next cycle shows out_undef=1 and out_valid=0. out_undef and out_valid are never high together.
- R3: The element index is the unsigned value of imm[4:k+1]. Index 0 is the least significant element of the source.
- R4: In vector form (scalar=0) with q=1, every lane of the 128-bit result holds the selected element.
- R5: In vector form with q=0, the low 64 bits hold copies of the element and bits 127:64 are zero.
- R6: Vector form with imm[3:0]=1000 and q=0 is undefined. Scalar form with the same immediate is legal.
- R7: In scalar form, the result holds the element in its low bits and zero above them, whatever q is.
- R8: A request on in_valid yields exactly one of out_valid or out_undef on the following cycle. A cycle with no request yields neither. Latency does not depend on data or encoding.
- R9: out_result keeps its value through idle cycles and undefined requests.
- R10: Reset clears out_valid, out_undef and out_result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_src | input | 128 | Source register value |
| in_imm | input | 5 | Width marker and element index |
| in_q | input | 1 | Vector destination width: 0 = 64 bits, 1 = 128 bits |
| in_scalar | input | 1 | 1 = scalar form, 0 = vector form |
| out_valid | output | 1 | Result is new this cycle |
| out_result | output | 128 | Registered result |
| out_undef | output | 1 | Request in the previous cycle was undefined |

## Verification
Undefined reporting and result retention meet in the same output slot. When an undefined request follows a legal one, out_undef rises in the very cycle in which out_result must still show the earlier value. The stimulus table provokes this by placing reserved and 64-bit/Q=0 vector encodings straight after legal rows, with no idle cycle between them. Each such slot is judged on three points: the flag is set, valid is low, and the result equals the last legal expected value tracked by the bench.

// File: rtl/vbu_pkg.sv
package vbu_pkg;
   localparam int VBU_REG_W  = 128;
   localparam int VBU_MIN_EW = 8;
   localparam int VBU_MAX_EW = 64;
   localparam int VBU_SZ_N   = $clog2(VBU_MAX_EW / VBU_MIN_EW) + 1;
   localparam int VBU_IMM_W  = VBU_SZ_N + 1;
endpackage

// File: rtl/vbu_decode.sv
module vbu_decode #(
   parameter int SZ_N  = vbu_pkg::VBU_SZ_N,
   localparam int IMM_W = SZ_N + 1,
   localparam int SZW   = (SZ_N > 1) ? $clog2(SZ_N) : 1,
   localparam int IDX_W = SZ_N
) (
   input  logic [IMM_W-1:0] imm,
   input  logic             q,
   input  logic             scalar,
   output logic [SZW-1:0]   sz,
   output logic [IDX_W-1:0] idx,
   output logic             undef
);
   logic found;

   always_comb begin
      sz    = '0;
      idx   = '0;
      found = |imm[SZ_N-1:0];
      // scan top-down so the lowest set marker bit is the last to win
      for (int k = SZ_N - 1; k >= 0; k--) begin
         if (imm[k]) begin
            sz  = SZW'(k);
            idx = IDX_W'(imm >> (k + 1));
         end
      end
      // the widest element needs a full-width vector destination
      undef = !found || (!scalar && !q && (sz == SZW'(SZ_N - 1)));
   end
endmodule

// File: rtl/vbu_select.sv
module vbu_select #(
   parameter int REG_W  = vbu_pkg::VBU_REG_W,
   parameter int MIN_EW = vbu_pkg::VBU_MIN_EW,
   parameter int SZ_N   = vbu_pkg::VBU_SZ_N,
   localparam int MAX_EW = MIN_EW << (SZ_N - 1),
   localparam int SZW    = (SZ_N > 1) ? $clog2(SZ_N) : 1,
   localparam int IDX_W  = SZ_N
) (
   input  logic [REG_W-1:0]  src,
   input  logic [SZW-1:0]    sz,
   input  logic [IDX_W-1:0]  idx,
   output logic [MAX_EW-1:0] elem
);
   logic [MAX_EW-1:0] cand [SZ_N];

   for (genvar s = 0; s < SZ_N; s++) begin : g_width
      localparam int EW  = MIN_EW << s;
      localparam int NL  = REG_W / EW;
      localparam int LIW = (NL > 1) ? $clog2(NL) : 1;
      logic [LIW-1:0] lane;
      assign lane    = idx[LIW-1:0];
      assign cand[s] = MAX_EW'(src[int'(lane)*EW +: EW]);
   end

   assign elem = cand[sz];
endmodule

// File: rtl/vbu_replicate.sv
module vbu_replicate #(
   parameter int REG_W  = vbu_pkg::VBU_REG_W,
   parameter int MIN_EW = vbu_pkg::VBU_MIN_EW,
   parameter int SZ_N   = vbu_pkg::VBU_SZ_N,
   localparam int MAX_EW = MIN_EW << (SZ_N - 1),
   localparam int HALF_W = REG_W / 2,
   localparam int SZW    = (SZ_N > 1) ? $clog2(SZ_N) : 1
) (
   input  logic [MAX_EW-1:0] elem,
   input  logic [SZW-1:0]    sz,
   input  logic              q,
   input  logic              scalar,
   output logic [REG_W-1:0]  result
);
   logic [REG_W-1:0] fan [SZ_N];
   logic [REG_W-1:0] one [SZ_N];

   for (genvar s = 0; s < SZ_N; s++) begin : g_width
      localparam int EW = MIN_EW << s;
      localparam int NL = REG_W / EW;
      assign fan[s] = {NL{elem[EW-1:0]}};
      assign one[s] = REG_W'(elem[EW-1:0]);
   end

   always_comb begin
      result = scalar ? one[sz] : fan[sz];
      if (!scalar && !q) result[REG_W-1:HALF_W] = '0;
   end
endmodule

// File: rtl/vec_bcast_unit.sv
module vec_bcast_unit #(
   parameter int REG_W  = vbu_pkg::VBU_REG_W,
   parameter int MIN_EW = vbu_pkg::VBU_MIN_EW,
   parameter int SZ_N   = vbu_pkg::VBU_SZ_N,
   localparam int IMM_W = SZ_N + 1,
   localparam int SZW   = (SZ_N > 1) ? $clog2(SZ_N) : 1,
   localparam int MAX_EW = MIN_EW << (SZ_N - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [REG_W-1:0] in_src,
   input  logic [IMM_W-1:0] in_imm,
   input  logic             in_q,
   input  logic             in_scalar,
   output logic             out_valid,
   output logic [REG_W-1:0] out_result,
   output logic             out_undef
);
   if (MAX_EW * 2 != REG_W) begin : g_bad_width
      $error("vec_bcast_unit: REG_W must be twice the widest element");
   end
   if (MIN_EW < 1 || (MIN_EW & (MIN_EW - 1)) != 0) begin : g_bad_min
      $error("vec_bcast_unit: MIN_EW must be a power of two");
   end

   logic [SZW-1:0]    sz;
   logic [SZ_N-1:0]   idx;
   logic              undef;
   logic [MAX_EW-1:0] elem;
   logic [REG_W-1:0]  nxt;

   vbu_decode #(.SZ_N(SZ_N)) u_dec (
      .imm(in_imm), .q(in_q), .scalar(in_scalar),
      .sz(sz), .idx(idx), .undef(undef)
   );

   vbu_select #(.REG_W(REG_W), .MIN_EW(MIN_EW), .SZ_N(SZ_N)) u_sel (
      .src(in_src), .sz(sz), .idx(idx), .elem(elem)
   );

   vbu_replicate #(.REG_W(REG_W), .MIN_EW(MIN_EW), .SZ_N(SZ_N)) u_rep (
      .elem(elem), .sz(sz), .q(in_q), .scalar(in_scalar), .result(nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_undef  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid && !undef;
         out_undef <= in_valid && undef;
         if (in_valid && !undef) out_result <= nxt;
      end
   end
endmodule

// File: rtl/vbu_checker.sv
module vbu_checker #(
   parameter int REG_W = 128,
   parameter int IMM_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [IMM_W-1:0] in_imm,
   input logic             in_q,
   input logic             in_scalar,
   input logic             out_valid,
   input logic [REG_W-1:0] out_result,
   input logic             out_undef
);
   AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_imm[IMM_W-2:0] == '0 |=> out_undef && !out_valid); // R2
   AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && out_undef)); // R2
   AST_WIDE_Q0: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_scalar && !in_q && in_imm[IMM_W-2:0] == (1 << (IMM_W-2)) |=> out_undef); // R6
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_q && in_imm[IMM_W-3:0] != '0 |=> out_result[REG_W-1:REG_W/2] == '0); // R5
   AST_SCALAR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_scalar && in_imm[0] |=> out_result[REG_W-1:8] == '0); // R7
   AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> $countones({out_valid, out_undef}) == 1); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !out_undef); // R8
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result)); // R9
endmodule

bind vec_bcast_unit vbu_checker #(.REG_W(REG_W), .IMM_W(IMM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_imm(in_imm),
   .in_q(in_q), .in_scalar(in_scalar), .out_valid(out_valid),
   .out_result(out_result), .out_undef(out_undef)
);

// File: tb/sim_vec_bcast_unit.sv
module sim_vec_bcast_unit;
   typedef struct packed {
      logic [4:0]   imm;
      logic         q;
      logic         sc;
      logic         bad;
      logic [127:0] exp;
   } vec_t;

   // source bytes: byte k = 8'hC0 + k
   localparam logic [127:0] SRC = 128'hCFCECDCCCBCAC9C8C7C6C5C4C3C2C1C0;
   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      '{5'b01011, 1'b1, 1'b0, 1'b0, {16{8'hC5}}},                      // R1 R3 R4 byte idx5
      '{5'b11111, 1'b0, 1'b0, 1'b0, {64'h0, {8{8'hCF}}}},              // R5 byte idx15
      '{5'b10110, 1'b1, 1'b0, 1'b0, {8{16'hCBCA}}},                    // R1 R3 half idx5
      '{5'b01100, 1'b0, 1'b0, 1'b0, {64'h0, {2{32'hC7C6C5C4}}}},       // R5 word idx1
      '{5'b11000, 1'b1, 1'b0, 1'b0, {2{64'hCFCECDCCCBCAC9C8}}},        // R4 dword idx1
      '{5'b01000, 1'b0, 1'b0, 1'b1, 128'h0},                           // R6 undefined
      '{5'b01000, 1'b0, 1'b1, 1'b0, {64'h0, 64'hC7C6C5C4C3C2C1C0}},    // R6 R7 scalar dword
      '{5'b00000, 1'b1, 1'b0, 1'b1, 128'h0},                           // R2 reserved
      '{5'b10000, 1'b0, 1'b1, 1'b1, 128'h0},                           // R2 reserved scalar
      '{5'b00011, 1'b1, 1'b1, 1'b0, {120'h0, 8'hC1}},                  // R7 q ignored
      '{5'b11110, 1'b0, 1'b1, 1'b0, {112'h0, 16'hCFCE}},               // R7 half idx7
      '{5'b10100, 1'b1, 1'b1, 1'b0, {96'h0, 32'hCBCAC9C8}},            // R7 word idx2
      '{5'b00001, 1'b1, 1'b0, 1'b0, {16{8'hC0}}}                       // R3 idx0
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] in_src = '0;
   logic [4:0]   in_imm = '0;
   logic         in_q = 1'b0;
   logic         in_scalar = 1'b0;
   logic         out_valid;
   logic [127:0] out_result;
   logic         out_undef;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;
   logic [127:0] last_good = '0;

   always #2 clk = ~clk;

   vec_bcast_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
      .in_imm(in_imm), .in_q(in_q), .in_scalar(in_scalar),
      .out_valid(out_valid), .out_result(out_result), .out_undef(out_undef)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic chk_row(input string req, input vec_t v);
      chk({req, " valid"}, 128'(out_valid), 128'(!v.bad));
      chk({req, " undef"}, 128'(out_undef), 128'(v.bad));
      chk({req, " result"}, out_result, v.bad ? last_good : v.exp);
      if (!v.bad) last_good = v.exp;
   endtask

   initial begin
      #(4 * 150000);
      nerr++;
      $display("FAIL watchdog expired");
      if (!done) $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      in_src = SRC;
      repeat (3) @(negedge clk);
      chk("R10 reset valid", 128'(out_valid), 128'h0);
      chk("R10 reset undef", 128'(out_undef), 128'h0);
      chk("R10 reset result", out_result, 128'h0);
      rst_n = 1'b1;

      // back-to-back table walk: drive row i, check row i-1
      for (int i = 0; i <= NV; i++) begin
         @(negedge clk);
         if (i > 0) chk_row($sformatf("R1-table row %0d", i - 1), TBL[i - 1]);
         if (i < NV) begin
            in_valid  = 1'b1;
            in_imm    = TBL[i].imm;
            in_q      = TBL[i].q;
            in_scalar = TBL[i].sc;
         end else begin
            in_valid = 1'b0;
         end
      end

      // R8 R9: idle cycles keep the result and raise nothing
      repeat (3) @(negedge clk);
      chk("R8 idle valid", 128'(out_valid), 128'h0);
      chk("R8 idle undef", 128'(out_undef), 128'h0);
      chk("R9 idle hold", out_result, last_good);

      // R8: different data, same one-cycle latency
      in_src = {8'h5A, {14{8'h00}}, 8'hA5};
      in_valid = 1'b1; in_imm = 5'b11111; in_q = 1'b1; in_scalar = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 latency valid", 128'(out_valid), 128'h1);
      chk("R4 byte15 new data", out_result, {16{8'h5A}});
      @(negedge clk);
      chk("R8 single pulse", 128'(out_valid), 128'h0);

      // R2 after idle: result still held
      in_valid = 1'b1; in_imm = 5'b00000; in_q = 1'b1; in_scalar = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 undef pulse", 128'(out_undef), 128'h1);
      chk("R9 held under undef", out_result, {16{8'h5A}});
      @(negedge clk);
      chk("R2 undef one cycle", 128'(out_undef), 128'h0);

      // R10: reset mid-stream
      in_valid = 1'b1; in_imm = 5'b00001; in_q = 1'b1; in_scalar = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      #1;
      chk("R10 async clear valid", 128'(out_valid), 128'h0);
      chk("R10 async clear result", out_result, 128'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule